// File: doc/BRIEF.md
# Modem Control and Status Register Block

This block holds the modem-side registers of a 16550-style serial port. It has a 5-bit control register that drives the four modem control outputs and a loopback enable. It also has a status register that reports the live level of the four modem inputs, together with one change-flag per input. Software reaches both registers through a simple strobe interface: a one-cycle read or write pulse plus an offset. Reads are combinational in the strobe cycle, and any clearing side effect takes place at the end of that cycle.

The four input lines are asynchronous. Each one passes through a two-flop synchroniser before the status logic compares it with the level it saw last time. A change sets that line's change-flag. For the ring line, only the end of a ring (high to low) sets the flag. Reading the status register clears the flags, but a change that lands in the same cycle as the read is kept. The interrupt request is raised while any flag is set.

In loopback, the control outputs are held inactive at the pins. A status read then returns the control bits, rearranged into the status positions, in place of the external lines. A loopback read does not clear the flags.

Top module: `mdm_ctl_stat`

## Requirements
- R1: After reset, a control read returns 0x08 (only the auxiliary-2 bit set). A status read returns 0xB0 (carrier, data-set-ready and clear-to-send high, no flags). The interrupt is low, and among the pins only pin_out2 is high.
- R2: A write at offset 4 stores bits [4:0] of the write data: dtr bit 0, rts bit 1, out1 bit 2, out2 bit 3, loopback bit 4. A control read returns them with bits [7:5] zero. Outside loopback, each pin follows its bit.
- R3: The status register at offset 6 reports the inputs in its upper nibble: carrier bit 7, ring bit 6, data-set-ready bit 5, clear-to-send bit 4. The level is visible to a read beginning three clock edges after the input change.
- R4: A change in either direction on clear-to-send, data-set-ready or carrier sets status bit 0, 1 or 3 respectively.
- R5: Status bit 2 sets only when the ring input goes from 1 to 0. A rising ring input leaves it clear.
- R6: A status read outside loopback clears bits [3:0] and leaves bits [7:4] unchanged. A change flag that sets on the same edge as the read survives it.
- R7: mdm_irq is high exactly while at least one of the four change flags is set.
- R8: In loopback, a status read returns out2 as bit 7, out1 as bit 6, dtr as bit 5 and rts as bit 4, with bits [3:0] zero. The read does not clear the stored flags.
- R9: While the loopback bit is set, pin_rts, pin_dtr, pin_out1 and pin_out2 are all low.
- R10: Reads at offsets other than 4 and 6 return 0. Writes at offsets other than 4 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high, zero otherwise |
| line_cts | input | 1 | Clear-to-send input, asynchronous, 1 = asserted |
| line_dsr | input | 1 | Data-set-ready input, asynchronous, 1 = asserted |
| line_dcd | input | 1 | Carrier-detect input, asynchronous, 1 = asserted |
| line_ri | input | 1 | Ring input, asynchronous, 1 = asserted |
| pin_rts | output | 1 | Request-to-send output |
| pin_dtr | output | 1 | Data-terminal-ready output |
| pin_out1 | output | 1 | Auxiliary output 1 |
| pin_out2 | output | 1 | Auxiliary output 2 |
| mdm_irq | output | 1 | Modem-status interrupt request |

## Verification
The properties assume the strobes and offset are free of X after reset. They also assume each line input holds its level for at least the synchroniser depth, so a level seen at the synchroniser output is a real change and not a glitch. Whether a read "clears everything" is judged only on cycles where no new change is arriving. The stimulus moves each line at most once per settle window, while the strobes are idle, with one deliberate exception: a change is placed so that its flag sets on the very edge of a status read. Inputs and strobes are driven two nanoseconds after the rising edge, so they never move at an edge.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  localparam int unsigned REG_W   = 8;
  localparam int unsigned NLINES  = 4;
  localparam int unsigned CTRL_W  = 5;
  localparam int unsigned RI_IDX  = 2;

  // Line order doubles as status nibble order: [3]=carrier [2]=ring [1]=dsr [0]=cts
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lines_t;

  // Control register layout, bit 4 down to bit 0
  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mdm_ctrl_t;

  localparam mdm_lines_t LINES_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
  localparam mdm_ctrl_t  CTRL_RST  = '{loop: 1'b0, out2: 1'b1, out1: 1'b0, rts: 1'b0, dtr: 1'b0};

  function automatic mdm_lines_t loop_map(input mdm_ctrl_t c);
    mdm_lines_t m;
    m.dcd = c.out2;
    m.ri  = c.out1;
    m.dsr = c.dtr;
    m.cts = c.rts;
    return m;
  endfunction

endpackage

// File: rtl/mdm_rst_sync.sv
module mdm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mdm_line_sync.sv
module mdm_line_sync #(
  parameter int unsigned          WIDTH   = 4,
  parameter int unsigned          STAGES  = 2,
  parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stage_d[g] = async_in;
    end else begin : g_next
      assign stage_d[g] = stage_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= RST_VAL;
      else        stage_q[g] <= stage_d[g];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [CTRL_W-1:0]          wr_val,
  output mdm_ctrl_t                  ctrl
);
  mdm_ctrl_t ctrl_q;
  mdm_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = mdm_ctrl_t'(wr_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/mdm_delta_track.sv
module mdm_delta_track
  import mdm_pkg::*;
#(
  parameter int unsigned FALL_ONLY_IDX = RI_IDX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] lines_in,
  input  logic              clr,
  output logic [NLINES-1:0] cur,
  output logic [NLINES-1:0] delta
);
  logic [NLINES-1:0] cur_q, cur_d;
  logic [NLINES-1:0] delta_q, delta_d;
  logic [NLINES-1:0] evt;

  for (genvar i = 0; i < NLINES; i++) begin : g_evt
    if (i == FALL_ONLY_IDX) begin : g_fall
      assign evt[i] = cur_q[i] & ~lines_in[i];
    end else begin : g_any
      assign evt[i] = cur_q[i] ^ lines_in[i];
    end
  end

  always_comb begin
    cur_d   = lines_in;
    delta_d = (delta_q & {NLINES{~clr}}) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= LINES_RST;
      delta_q <= '0;
    end else begin
      cur_q   <= cur_d;
      delta_q <= delta_d;
    end
  end

  assign cur   = cur_q;
  assign delta = delta_q;
endmodule

// File: rtl/mdm_ctl_stat.sv
module mdm_ctl_stat
  import mdm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned CTRL_OFS    = 4,
  parameter int unsigned STAT_OFS    = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              line_cts,
  input  logic              line_dsr,
  input  logic              line_dcd,
  input  logic              line_ri,
  output logic              pin_rts,
  output logic              pin_dtr,
  output logic              pin_out1,
  output logic              pin_out2,
  output logic              mdm_irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam int unsigned       PAD_W  = REG_W - CTRL_W;

  logic        rst_n_s;
  mdm_lines_t  raw_lines;
  mdm_lines_t  sync_lines;
  mdm_ctrl_t   ctrl;
  logic [NLINES-1:0] cur_lines;
  logic [NLINES-1:0] delta;
  logic        ctrl_wr;
  logic        stat_rd;
  logic        delta_clr;
  logic        unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[REG_W-1:CTRL_W];

  mdm_rst_sync #(.STAGES(RST_STAGES)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    raw_lines.dcd = line_dcd;
    raw_lines.ri  = line_ri;
    raw_lines.dsr = line_dsr;
    raw_lines.cts = line_cts;
  end

  mdm_line_sync #(
    .WIDTH  (NLINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINES_RST)
  ) sync_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .async_in (raw_lines),
    .sync_out (sync_lines)
  );

  assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
  assign stat_rd   = reg_rd && (reg_addr == A_STAT);
  assign delta_clr = stat_rd && !ctrl.loop;

  mdm_ctrl_reg ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_en  (ctrl_wr),
    .wr_val (reg_wdata[CTRL_W-1:0]),
    .ctrl   (ctrl)
  );

  mdm_delta_track #(.FALL_ONLY_IDX(RI_IDX)) delta_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .lines_in (sync_lines),
    .clr      (delta_clr),
    .cur      (cur_lines),
    .delta    (delta)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == A_CTRL) begin
        reg_rdata = {{PAD_W{1'b0}}, ctrl};
      end else if (reg_addr == A_STAT) begin
        if (ctrl.loop) reg_rdata = {loop_map(ctrl), {NLINES{1'b0}}};
        else           reg_rdata = {cur_lines, delta};
      end
    end
  end

  assign pin_rts  = ctrl.rts  & ~ctrl.loop;
  assign pin_dtr  = ctrl.dtr  & ~ctrl.loop;
  assign pin_out1 = ctrl.out1 & ~ctrl.loop;
  assign pin_out2 = ctrl.out2 & ~ctrl.loop;
  assign mdm_irq  = |delta;

endmodule

// File: rtl/mdm_ctl_stat_chk.sv
module mdm_ctl_stat_chk #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned CTRL_OFS = 4,
  parameter int unsigned STAT_OFS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic [7:0]        reg_rdata,
  input logic              loop,
  input logic [3:0]        sync_lines,
  input logic [3:0]        cur_lines,
  input logic [3:0]        delta,
  input logic              mdm_irq,
  input logic [3:0]        pins
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

  p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CTRL) |-> (reg_rdata[7:5] == 3'b000));

  p_stat_follows_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cur_lines == $past(sync_lines)));

  p_ring_rise_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_lines[2] && sync_lines[2] && !delta[2]) |=> !delta[2]);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_STAT && !loop && sync_lines == cur_lines) |=> (delta == 4'b0000));

  p_irq_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdm_irq) |-> $past(sync_lines != cur_lines));

  p_loop_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_STAT && loop) |=> ((delta & $past(delta)) == $past(delta)));

  p_loop_pins_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loop |-> (pins == 4'b0000));

endmodule

bind mdm_ctl_stat mdm_ctl_stat_chk #(
  .ADDR_W   (ADDR_W),
  .CTRL_OFS (CTRL_OFS),
  .STAT_OFS (STAT_OFS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .reg_addr   (reg_addr),
  .reg_rd     (reg_rd),
  .reg_rdata  (reg_rdata),
  .loop       (ctrl.loop),
  .sync_lines (sync_lines),
  .cur_lines  (cur_lines),
  .delta      (delta),
  .mdm_irq    (mdm_irq),
  .pins       ({pin_out2, pin_out1, pin_rts, pin_dtr})
);

// File: tb/mdm_ctl_stat_tb_top.sv
module mdm_ctl_stat_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       line_cts = 1'b1;
  logic       line_dsr = 1'b1;
  logic       line_dcd = 1'b1;
  logic       line_ri  = 1'b0;
  logic       pin_rts, pin_dtr, pin_out1, pin_out2, mdm_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } rd_item_t;
  rd_item_t exp_q[$];

  always #5 clk = ~clk;

  mdm_ctl_stat dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_cts(line_cts), .line_dsr(line_dsr), .line_dcd(line_dcd), .line_ri(line_ri),
    .pin_rts(pin_rts), .pin_dtr(pin_dtr), .pin_out1(pin_out1), .pin_out2(pin_out2),
    .mdm_irq(mdm_irq)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic settle();
    repeat (4) step();
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    reg_addr = a; reg_rd = 1'b1;
    step();
    reg_rd = 1'b0;
  endtask

  function automatic logic [7:0] pins_v();
    return {4'b0, pin_out2, pin_out1, pin_rts, pin_dtr};
  endfunction

  // Monitor: consumes one expected item per read strobe
  always @(negedge clk) begin
    if (rst_n && reg_rd) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL unexpected read actual=0x%02h expected=none", reg_rdata);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        chk(reg_rdata, it.exp, it.tag);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (6) step();

    // R1 reset state
    rd(3'd4, 8'h08, "R1 ctrl reset");
    rd(3'd6, 8'hB0, "R1 status reset");
    chk({7'b0, mdm_irq}, 8'h00, "R1 irq reset");
    chk(pins_v(), 8'h08, "R1 pins reset");

    // R2 control write
    wr(3'd4, 8'hE3);
    rd(3'd4, 8'h03, "R2 upper bits dropped");
    chk(pins_v(), 8'h03, "R2 pins rts dtr");
    wr(3'd4, 8'h0F);
    rd(3'd4, 8'h0F, "R2 all outputs");
    chk(pins_v(), 8'h0F, "R2 pins all");

    // R3 R4 R7 cts change
    line_cts = 1'b0; settle();
    chk({7'b0, mdm_irq}, 8'h01, "R7 irq on cts change");
    rd(3'd6, 8'hA1, "R3 R4 cts fall");
    rd(3'd6, 8'hA0, "R6 flags cleared");
    chk({7'b0, mdm_irq}, 8'h00, "R7 irq cleared");

    line_dsr = 1'b0; line_dcd = 1'b0; settle();
    rd(3'd6, 8'h0A, "R4 dsr dcd fall");
    rd(3'd6, 8'h00, "R6 cleared");

    // R5 ring
    line_ri = 1'b1; settle();
    rd(3'd6, 8'h40, "R5 ring rise no flag");
    chk({7'b0, mdm_irq}, 8'h00, "R5 irq quiet on ring rise");
    line_ri = 1'b0; settle();
    rd(3'd6, 8'h04, "R5 ring fall flag");
    rd(3'd6, 8'h00, "R6 cleared after ring");

    // R6 flag arriving on the read edge survives
    line_cts = 1'b1;
    step(); step();
    rd(3'd6, 8'h00, "R6 read on arrival edge");
    rd(3'd6, 8'h11, "R6 same-edge flag kept");
    rd(3'd6, 8'h10, "R6 cleared after");

    // R8 R9 loopback
    line_dsr = 1'b1; settle();
    chk({7'b0, mdm_irq}, 8'h01, "R7 irq dsr rise");
    wr(3'd4, 8'h1F);
    chk(pins_v(), 8'h00, "R9 pins idle in loop");
    rd(3'd6, 8'hF0, "R8 loop all ones");
    chk({7'b0, mdm_irq}, 8'h01, "R8 loop read keeps irq");
    wr(3'd4, 8'h15);
    chk(pins_v(), 8'h00, "R9 pins idle loop 15");
    rd(3'd6, 8'h60, "R8 out1 dtr map");
    wr(3'd4, 8'h1A);
    rd(3'd6, 8'h90, "R8 out2 rts map");
    wr(3'd4, 8'h08);
    chk(pins_v(), 8'h08, "R9 pins back after loop");
    rd(3'd6, 8'h32, "R8 flag kept through loop");
    rd(3'd6, 8'h30, "R6 cleared after loop");

    // R10 other offsets
    rd(3'd0, 8'h00, "R10 offset 0");
    rd(3'd1, 8'h00, "R10 offset 1");
    rd(3'd2, 8'h00, "R10 offset 2");
    rd(3'd3, 8'h00, "R10 offset 3");
    rd(3'd5, 8'h00, "R10 offset 5");
    rd(3'd7, 8'h00, "R10 offset 7");
    wr(3'd6, 8'hFF);
    rd(3'd6, 8'h30, "R10 status write ignored");
    wr(3'd5, 8'h1F);
    wr(3'd3, 8'h13);
    rd(3'd4, 8'h08, "R10 ctrl untouched");
    chk({7'b0, mdm_irq}, 8'h00, "R10 irq untouched");

    step();
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard actual=%0d expected=0 pending reads", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule